// File: doc/BRIEF.md
# Prioritised Dual Status Lamp Encoder

This block turns the health conditions of a field-bus slave node into drive levels for two indicator lamps: a green one and a red one. Several conditions can be present at the same time. The block ranks them and shows only the most urgent, using a fixed pattern of steady, dark and blinking lamps for each.

A free-running blink generator sets the slow blink rate. The generator is cleared only by the hard reset (`rst_n`). The soft-reset condition is one of the displayed states and never touches the blink timer, so the blink phase runs on without a break while a soft reset is shown.

Both lamp lines are active low and registered. Electrical drive of the lamps is handled outside the block.

Top module: `led_status_encoder`

## Requirements
- R1: While `rst_n` is low, `green_n` and `red_n` are both 1 (both lamps dark).
- R2: When `supply_ok` is 0, both outputs are 1 regardless of every other input.
- R3: Lamp lines are active low (0 = lit) and registered. They show the state of the inputs and of the blink phase one clock edge later. With no condition present, green is lit and red is dark.
- R4: Priority 1 is `soft_reset` = 1 or `supply_overload` = 1. Green is dark and red blinks.
- R5: Priority 2 is `periph_fault_n` = 0. Green and red blink in opposite phase, so exactly one of them is lit.
- R6: Priority 3 is `addr_zero` = 1 or `addr_mismatch` = 1. Green blinks and red is steadily lit.
- R7: Priority 4 is `wdog_fired` = 1. Green is dark and red is steadily lit.
- R8: When conditions of several priorities are present together, only the pattern of the highest one (lowest number) is shown.
- R9: The blink phase starts at 0 after hard reset and toggles every H = CLK_HZ*5/BLINK_HZ_X10 clock cycles. BLINK_HZ_X10 is the blink rate in tenths of a hertz, from 20 to 30. A blinking lamp is lit while the phase is 1; its opposite-phase partner is lit while the phase is 0.
- R10: Asserting `soft_reset` does not disturb the blink phase, which keeps counting across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| supply_ok | input | 1 | Field supply present |
| soft_reset | input | 1 | Soft reset in progress |
| supply_overload | input | 1 | Field supply switched off by overload |
| periph_fault_n | input | 1 | Peripheral hardware fault, active low |
| addr_zero | input | 1 | Stored slave address is zero |
| addr_mismatch | input | 1 | The two stored address copies disagree |
| wdog_fired | input | 1 | Communication watchdog has expired |
| green_n | output | 1 | Green lamp drive, active low |
| red_n | output | 1 | Red lamp drive, active low |

## Verification
The bench builds the block with CLK_HZ = 40 and BLINK_HZ_X10 = 25. This gives a half period of 8 cycles instead of about a million, so each held pattern passes through both blink phases within 20 cycles.

With the short period, the bench can also:
- hold a soft reset for a span that is not a multiple of the half period, then confirm that the blink phase continues on the uninterrupted count;
- pulse the hard reset in mid-phase and confirm that the phase restarts from zero.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

   typedef enum logic [2:0] {
      SHOW_DARK,
      SHOW_HALT,
      SHOW_PERIPH,
      SHOW_NOADDR,
      SHOW_NOCOMM,
      SHOW_RUN
   } show_e;

   typedef enum logic [1:0] {
      LAMP_OFF,
      LAMP_ON,
      LAMP_BLINK,
      LAMP_BLINK_INV
   } lamp_e;

   localparam int unsigned LAMP_GREEN = 0;
   localparam int unsigned LAMP_RED   = 1;
   localparam int unsigned NUM_LAMPS  = 2;

   // Pattern table: one mode per lamp for each displayed state.
   function automatic lamp_e lamp_mode(input show_e s, input int unsigned lamp);
      lamp_e m;
      m = LAMP_OFF;
      case (s)
         SHOW_DARK:   m = LAMP_OFF;
         SHOW_HALT:   m = (lamp == LAMP_RED)   ? LAMP_BLINK : LAMP_OFF;
         SHOW_PERIPH: m = (lamp == LAMP_GREEN) ? LAMP_BLINK : LAMP_BLINK_INV;
         SHOW_NOADDR: m = (lamp == LAMP_GREEN) ? LAMP_BLINK : LAMP_ON;
         SHOW_NOCOMM: m = (lamp == LAMP_RED)   ? LAMP_ON    : LAMP_OFF;
         SHOW_RUN:    m = (lamp == LAMP_GREEN) ? LAMP_ON    : LAMP_OFF;
         default:     m = LAMP_OFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
   parameter int unsigned HALF_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt == LAST);

   // Cleared by hard reset only; no soft-reset input exists here.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 1'b0;
      end else if (wrap) begin
         phase <= ~phase;
      end
   end

   assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(phase));

   assert_phase_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (phase != $past(phase)));

endmodule

// File: rtl/led_status_arbiter.sv
module led_status_arbiter
   import led_status_pkg::*;
(
   input  logic  supply_ok,
   input  logic  soft_reset,
   input  logic  supply_overload,
   input  logic  periph_fault_n,
   input  logic  addr_zero,
   input  logic  addr_mismatch,
   input  logic  wdog_fired,
   output show_e show
);
   always_comb begin
      if (!supply_ok) begin
         show = SHOW_DARK;
      end else if (soft_reset || supply_overload) begin
         show = SHOW_HALT;
      end else if (!periph_fault_n) begin
         show = SHOW_PERIPH;
      end else if (addr_zero || addr_mismatch) begin
         show = SHOW_NOADDR;
      end else if (wdog_fired) begin
         show = SHOW_NOCOMM;
      end else begin
         show = SHOW_RUN;
      end
   end
endmodule

// File: rtl/led_lamp_driver.sv
module led_lamp_driver
   import led_status_pkg::*;
#(
   parameter int unsigned LAMPS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phase,
   input  lamp_e            mode [LAMPS],
   output logic [LAMPS-1:0] lamp_n
);
   for (genvar i = 0; i < LAMPS; i++) begin : g_lamp
      logic lit;

      always_comb begin
         case (mode[i])
            LAMP_ON:        lit = 1'b1;
            LAMP_BLINK:     lit = phase;
            LAMP_BLINK_INV: lit = ~phase;
            default:        lit = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lamp_n[i] <= 1'b1;
         end else begin
            lamp_n[i] <= ~lit;
         end
      end

      assert_lamp_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode[i] == LAMP_ON) |=> !lamp_n[i]);

      assert_lamp_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode[i] == LAMP_OFF) |=> lamp_n[i]);
   end
endmodule

// File: rtl/led_status_encoder.sv
module led_status_encoder
   import led_status_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 5333333,
   parameter int unsigned BLINK_HZ_X10 = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic soft_reset,
   input  logic supply_overload,
   input  logic periph_fault_n,
   input  logic addr_zero,
   input  logic addr_mismatch,
   input  logic wdog_fired,
   output logic green_n,
   output logic red_n
);
   localparam int unsigned HALF_CYCLES = (CLK_HZ * 5) / BLINK_HZ_X10;

   initial begin
      assert (BLINK_HZ_X10 >= 20 && BLINK_HZ_X10 <= 30)
         else $error("blink rate out of 2..3 Hz");
      assert (CLK_HZ <= 800000000) else $error("clock rate too large");
      assert (HALF_CYCLES >= 2) else $error("half period below two cycles");
   end

   show_e                  show;
   lamp_e                  mode [NUM_LAMPS];
   logic                   phase;
   logic [NUM_LAMPS-1:0]   lamp_n;

   led_blink_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   led_status_arbiter u_arb (
      .supply_ok       (supply_ok),
      .soft_reset      (soft_reset),
      .supply_overload (supply_overload),
      .periph_fault_n  (periph_fault_n),
      .addr_zero       (addr_zero),
      .addr_mismatch   (addr_mismatch),
      .wdog_fired      (wdog_fired),
      .show            (show)
   );

   for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_mode
      assign mode[i] = lamp_mode(show, i);
   end

   led_lamp_driver #(.LAMPS(NUM_LAMPS)) u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (phase),
      .mode   (mode),
      .lamp_n (lamp_n)
   );

   assign green_n = lamp_n[LAMP_GREEN];
   assign red_n   = lamp_n[LAMP_RED];

   assert_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (green_n && red_n));

   assert_halt_green_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && (soft_reset || supply_overload)) |=> green_n);

   assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && !soft_reset && !supply_overload && !periph_fault_n)
      |=> (green_n != red_n));

   assert_noaddr_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && !soft_reset && !supply_overload && periph_fault_n
       && (addr_zero || addr_mismatch)) |=> !red_n);

   assert_nocomm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && !soft_reset && !supply_overload && periph_fault_n
       && !addr_zero && !addr_mismatch && wdog_fired) |=> (green_n && !red_n));

endmodule

// File: tb/led_status_encoder_bench.sv
module led_status_encoder_bench;
   localparam int unsigned CLK_HZ = 40;
   localparam int unsigned BLINK  = 25;
   localparam int unsigned H      = CLK_HZ * 5 / BLINK;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b1, soft_reset = 1'b0, supply_overload = 1'b0;
   logic periph_fault_n = 1'b1, addr_zero = 1'b0, addr_mismatch = 1'b0, wdog_fired = 1'b0;
   logic green_n, red_n;

   always #5 clk = ~clk;

   led_status_encoder #(.CLK_HZ(CLK_HZ), .BLINK_HZ_X10(BLINK)) u_led_status_encoder (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .soft_reset(soft_reset),
      .supply_overload(supply_overload), .periph_fault_n(periph_fault_n),
      .addr_zero(addr_zero), .addr_mismatch(addr_mismatch), .wdog_fired(wdog_fired),
      .green_n(green_n), .red_n(red_n)
   );

   typedef struct {
      logic [1:0] expv;
      string      tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails  = 0;
   int edges  = 0;
   bit done   = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   // Expected {green_n, red_n} from the requirement text.
   function automatic logic [1:0] expect_out(input logic ph);
      logic g, r;
      if (!supply_ok) begin
         g = 0; r = 0;
      end else if (soft_reset || supply_overload) begin
         g = 0; r = ph;
      end else if (!periph_fault_n) begin
         g = ph; r = !ph;
      end else if (addr_zero || addr_mismatch) begin
         g = ph; r = 1;
      end else if (wdog_fired) begin
         g = 0; r = 1;
      end else begin
         g = 1; r = 0;
      end
      return {!g, !r};
   endfunction

   task automatic set_in(input logic sup, input logic sr, input logic ov, input logic fn,
                         input logic az, input logic mm, input logic wd);
      supply_ok = sup; soft_reset = sr; supply_overload = ov; periph_fault_n = fn;
      addr_zero = az; addr_mismatch = mm; wdog_fired = wd;
   endtask

   // Driver: hold inputs for n cycles, queue the expected output of each edge.
   task automatic drive(input logic sup, input logic sr, input logic ov, input logic fn,
                        input logic az, input logic mm, input logic wd,
                        input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         item_t it;
         @(negedge clk);
         set_in(sup, sr, ov, fn, az, mm, wd);
         it.expv = expect_out(logic'((edges / H) % 2));
         it.tag  = tag;
         q.push_back(it);
      end
      @(posedge clk);
      #3;
   endtask

   // Monitor: compare each result just after the edge that produced it.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ({green_n, red_n} !== it.expv) begin
               fails++;
               $display("FAIL %s: got {green_n,red_n}=%b expected %b", it.tag,
                        {green_n, red_n}, it.expv);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if ({green_n, red_n} !== 2'b11) begin
         fails++;
         $display("FAIL R1: got %b expected 11", {green_n, red_n});
      end
      @(negedge clk);
      rst_n = 1'b1;

      drive(1, 0, 0, 1, 0, 0, 0, 20, "R3 regular");
      drive(1, 1, 0, 1, 0, 0, 0, 20, "R4 soft reset");
      drive(1, 0, 1, 1, 0, 0, 0, 20, "R4 overload");
      drive(1, 0, 0, 0, 0, 0, 0, 20, "R5 periph fault");
      drive(1, 0, 0, 1, 1, 0, 0, 20, "R6 address zero");
      drive(1, 0, 0, 1, 0, 1, 0, 20, "R6 address mismatch");
      drive(1, 0, 0, 1, 0, 0, 1, 20, "R7 watchdog");
      drive(0, 1, 1, 0, 1, 1, 1, 10, "R2 no supply");
      drive(0, 0, 0, 1, 0, 0, 0, 5,  "R2 no supply idle");
      drive(1, 1, 0, 0, 1, 0, 1, 20, "R8 halt over all");
      drive(1, 0, 0, 0, 0, 1, 1, 20, "R8 fault over address");
      drive(1, 0, 0, 1, 1, 0, 1, 20, "R8 address over watchdog");
      drive(1, 0, 0, 1, 0, 0, 0, 3,  "R3 back to regular");
      // R10: soft reset for a span off the half-period grid, phase keeps counting
      drive(1, 1, 0, 1, 0, 0, 0, 13, "R10 soft reset span");
      drive(1, 0, 0, 0, 0, 0, 0, 20, "R10 phase continues");

      // R9: hard reset in mid-phase restarts the phase at zero
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      checks++;
      if ({green_n, red_n} !== 2'b11) begin
         fails++;
         $display("FAIL R1: got %b expected 11 in reset", {green_n, red_n});
      end
      rst_n = 1'b1;
      drive(1, 0, 0, 0, 0, 0, 0, 2 * H + 4, "R9 phase restart");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule